// File: doc/BRIEF.md
# HDLC Transmit Framer with Underrun Recovery

This block converts a stream of bytes into a synchronous HDLC bit stream. It sends one line bit for each `bit_tick` pulse. Frames are wrapped in flag octets, and a zero is stuffed after any run of five ones inside the frame body. When the CRC-at-end mode is on, a 16-bit CRC follows the frame body. Between frames the line carries either repeated flags or marking ones, as the `idle_ones` mode selects.

A frame can end in two separate ways. The normal way is a byte tagged as last, followed by the optional CRC and one closing flag. A byte is tagged as last in one of three ways: its own `in_eof` bit, a one-shot `set_eof` command, or a loadable character counter reaching zero.

The second way is an underrun. This happens when the shifter needs the next byte of an open frame and the byte input is not valid. The block then pulses `tx_underrun` and sends one of four recovery sequences chosen by `urun_mode`. Mode and command inputs are plain level and strobe pins. They should only change while no frame is open.

Byte input follows valid/ready rules:
- `in_ready` rises only in a `bit_tick` cycle in which the shifter needs a byte. It does not depend on `in_valid`.
- A byte transfers in a cycle where both `in_valid` and `in_ready` are high.
- A source that raises `in_valid` must hold it, with stable data, until the transfer happens.
- Inside a frame, a missing byte is not waited for: it is an underrun.

Top module: `hdlc_tx_framer`

## Requirements
- R1: While `rst_n` is low, `tx_bit` is 1, `tx_bit_en`, `tx_underrun`, `tx_frame_end` and `in_ready` are 0, and no frame is open.
- R2: Each cycle with `bit_tick` high produces exactly one line bit: `tx_bit_en` is high in the following cycle and `tx_bit` then holds the new bit. Without a tick, `tx_bit` keeps its value and `tx_bit_en` is low.
- R3: `in_ready` is high only in a tick cycle where the shifter is empty, no stuffed zero is due, and either a frame is open or the previous segment was a flag. A byte is taken when `in_valid` and `in_ready` are both high.
- R4: Every octet is sent least significant bit first. The flag octet is 0x7E, which goes out as 0,1,1,1,1,1,1,0. An opening flag always precedes the first byte of a frame unless R9 applies.
- R5: After five consecutive ones of data or CRC, one extra 0 is sent before anything else. Flags, aborts and idle ones are never stuffed, and they clear the run of ones.
- R6: The CRC uses x^16+x^12+x^5+1 in reflected form (0x8408). It is preset to 0xFFFF on the first byte of a frame and runs over the unstuffed data bits. It is sent complemented, least significant bit first, and is itself stuffed.
- R7: A loaded byte is the last of its frame when any of these holds:
  - `in_eof` is high on it;
  - `set_eof` was pulsed since the previous load or in the same cycle;
  - the character counter equals 1 when the byte loads.

  `cnt_load` presets the counter from `cnt_preset` and wins over the decrement. Every loaded byte decrements a nonzero counter. `tx_frame_end` pulses, aligned with the first bit of the last byte.
- R8: After the last byte, the block sends the CRC when `crc_at_end` is 1, then one closing flag.
- R9: If `in_valid` is high when a flag completes outside a frame, the next frame's first byte follows that flag at once, so one flag serves both frames.
- R10: With nothing to send, the line idles. With `idle_ones`=1 it sends groups of eight ones. With `idle_ones`=0 it sends back-to-back flags. Data waiting after idle ones gets an opening flag first.
- R11: When an open frame needs a byte and `in_valid` is low, `tx_underrun` pulses, aligned with the first bit of the response. `urun_mode` selects the response:
  - 00: seven ones;
  - 01: fifteen ones;
  - 10: a flag;
  - 11: the CRC gathered so far, then a flag.

  `tx_underrun` and `tx_frame_end` never pulse together.
- R12: After an abort (modes 00 and 01), the frame is closed and the next data is preceded by an opening flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | Line bit enable, one bit per pulse |
| in_valid | input | 1 | Byte input valid |
| in_ready | output | 1 | Byte input ready |
| in_data | input | 8 | Byte to send, LSB first |
| in_eof | input | 1 | Byte is last of its frame |
| idle_ones | input | 1 | 1: idle line is ones, 0: idle flags |
| crc_at_end | input | 1 | Append CRC after the last byte |
| urun_mode | input | 2 | Underrun response select |
| set_eof | input | 1 | Strobe: tag next loaded byte as last |
| cnt_load | input | 1 | Strobe: preset character counter |
| cnt_preset | input | CNT_W (12) | Character counter preset |
| tx_bit | output | 1 | Serial line bit |
| tx_bit_en | output | 1 | New line bit presented this cycle |
| tx_underrun | output | 1 | Pulse: underrun response started |
| tx_frame_end | output | 1 | Pulse: last byte of a frame started |

## Verification
Two things can coincide on the same tick: a stuffed zero that falls due right as a segment runs out, and the decision for the next segment (load, underrun response, CRC or closing flag). The stuffed zero must win and the decision must slip by one tick. This is provoked with all-ones data and with CRC values that end in ones, under an irregular tick pattern. A second pairing is a byte load in the same cycle as a `set_eof` or `cnt_load` strobe. A behavioural bench model predicts every line bit, strobe and ready level on each clock. A bit that differs is reported under the requirement that produced it (stuffing, CRC, flag, abort or idle).

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  localparam int BYTE_W      = 8;
  localparam int CRC_W       = 16;
  localparam int SEG_W       = CRC_W;
  localparam int LEFT_W      = $clog2(SEG_W + 1);
  localparam int RUN_W       = 3;
  localparam int ABORT_SHORT = 7;
  localparam int ABORT_LONG  = 15;

  localparam logic [RUN_W-1:0] STUFF_RUN    = 3'd5;
  localparam logic [BYTE_W-1:0] FLAG_OCTET  = 8'h7E;
  localparam logic [CRC_W-1:0]  CRC_POLY_RV = 16'h8408;
  localparam logic [CRC_W-1:0]  CRC_SEED    = 16'hFFFF;

  // where the frame sequencer stands between segments
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_BODY  = 2'd1,
    PH_CRC   = 2'd2,
    PH_CLOSE = 2'd3
  } tx_phase_e;

  // which segment the shifter loads next
  typedef enum logic [2:0] {
    SEG_NONE    = 3'd0,
    SEG_FLAG    = 3'd1,
    SEG_MARK    = 3'd2,
    SEG_DATA    = 3'd3,
    SEG_CRC     = 3'd4,
    SEG_ABORT7  = 3'd5,
    SEG_ABORT15 = 3'd6
  } seg_e;

  typedef enum logic [1:0] {
    UR_ABORT    = 2'd0,
    UR_ABORT_X  = 2'd1,
    UR_FLAG     = 2'd2,
    UR_CRC_FLAG = 2'd3
  } urun_e;
endpackage

// File: rtl/hdlc_tx_crc16.sv
module hdlc_tx_crc16
  import hdlc_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             feed,
  input  logic             din,
  output logic [CRC_W-1:0] crc_q
);
  logic [CRC_W-1:0] base;
  logic [CRC_W-1:0] crc_d;
  logic             fb;

  always_comb begin
    base  = init ? CRC_SEED : crc_q;
    fb    = base[0] ^ din;
    crc_d = base;
    if (feed) begin
      crc_d = {1'b0, base[CRC_W-1:1]};
      if (fb) crc_d = crc_d ^ CRC_POLY_RV;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= CRC_SEED;
    else        crc_q <= crc_d;
  end

  // R6
  crc_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init && !feed) |=> (crc_q == CRC_SEED));

  // R6
  crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && !feed) |=> $stable(crc_q));
endmodule

// File: rtl/hdlc_tx_eof_tag.sv
module hdlc_tx_eof_tag #(
  parameter int CNT_W        = 12,
  parameter bit HAS_CHAR_CNT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             in_eof,
  input  logic             set_eof,
  input  logic             cnt_load,
  input  logic [CNT_W-1:0] cnt_preset,
  output logic             tag_eof
);
  logic pend_q;
  logic cnt_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pend_q <= 1'b0;
    else if (load) pend_q <= 1'b0;
    else if (set_eof) pend_q <= 1'b1;
  end

  generate
    if (HAS_CHAR_CNT) begin : g_cnt
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      cnt_q <= '0;
        else if (cnt_load)               cnt_q <= cnt_preset;
        else if (load && (cnt_q != '0))  cnt_q <= cnt_q - CNT_W'(1);
      end

      assign cnt_hit = (cnt_q == CNT_W'(1));

      // R7
      cnt_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_load |=> (cnt_q == $past(cnt_preset)));

      // R7
      cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !cnt_load && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
    end else begin : g_nocnt
      assign cnt_hit = 1'b0;
    end
  endgenerate

  assign tag_eof = in_eof | set_eof | pend_q | cnt_hit;
endmodule

// File: rtl/hdlc_tx_plan.sv
module hdlc_tx_plan
  import hdlc_tx_pkg::*;
(
  input  tx_phase_e   phase_q,
  input  logic        last_flag_q,
  input  logic        in_valid,
  input  logic        idle_ones,
  input  logic        crc_at_end,
  input  logic [1:0]  urun_mode,
  input  logic        tag_eof,
  output seg_e        seg_sel,
  output tx_phase_e   phase_nx,
  output logic        lf_nx,
  output logic        wants_byte,
  output logic        urun_hit
);
  tx_phase_e after_byte;

  always_comb begin
    if (!tag_eof)        after_byte = PH_BODY;
    else if (crc_at_end) after_byte = PH_CRC;
    else                 after_byte = PH_CLOSE;
  end

  always_comb begin
    seg_sel    = SEG_NONE;
    phase_nx   = phase_q;
    lf_nx      = last_flag_q;
    wants_byte = 1'b0;
    urun_hit   = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        wants_byte = last_flag_q;
        if (last_flag_q && in_valid) begin
          seg_sel  = SEG_DATA;
          phase_nx = after_byte;
        end else if (in_valid || !idle_ones) begin
          seg_sel = SEG_FLAG;
          lf_nx   = 1'b1;
        end else begin
          seg_sel = SEG_MARK;
          lf_nx   = 1'b0;
        end
      end
      PH_BODY: begin
        wants_byte = 1'b1;
        if (in_valid) begin
          seg_sel  = SEG_DATA;
          phase_nx = after_byte;
        end else begin
          urun_hit = 1'b1;
          unique case (urun_e'(urun_mode))
            UR_ABORT: begin
              seg_sel  = SEG_ABORT7;
              phase_nx = PH_IDLE;
              lf_nx    = 1'b0;
            end
            UR_ABORT_X: begin
              seg_sel  = SEG_ABORT15;
              phase_nx = PH_IDLE;
              lf_nx    = 1'b0;
            end
            UR_FLAG: begin
              seg_sel  = SEG_FLAG;
              phase_nx = PH_IDLE;
              lf_nx    = 1'b1;
            end
            default: begin
              seg_sel  = SEG_CRC;
              phase_nx = PH_CLOSE;
            end
          endcase
        end
      end
      PH_CRC: begin
        seg_sel  = SEG_CRC;
        phase_nx = PH_CLOSE;
      end
      default: begin
        seg_sel  = SEG_FLAG;
        phase_nx = PH_IDLE;
        lf_nx    = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
  import hdlc_tx_pkg::*;
#(
  parameter int CNT_W        = 12,
  parameter bit HAS_CHAR_CNT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_eof,
  input  logic             idle_ones,
  input  logic             crc_at_end,
  input  logic [1:0]       urun_mode,
  input  logic             set_eof,
  input  logic             cnt_load,
  input  logic [CNT_W-1:0] cnt_preset,
  output logic             tx_bit,
  output logic             tx_bit_en,
  output logic             tx_underrun,
  output logic             tx_frame_end
);
  logic [SEG_W-1:0]  sh_q, sh_d;
  logic [LEFT_W-1:0] left_q, left_d;
  logic              st_q, st_d;
  logic              fd_q, fd_d;
  logic [RUN_W-1:0]  ones_q, ones_d;
  tx_phase_e         phase_q, phase_d;
  logic              lf_q, lf_d;
  logic              bit_q, en_q, ur_q, fe_q;

  logic              stuff_due, slot, load;
  logic              out_bit, cur_st, feed;
  seg_e              seg_sel;
  tx_phase_e         phase_nx;
  logic              lf_nx, wants_byte, urun_hit, tag_eof;
  logic [CRC_W-1:0]  crc_q;
  logic [SEG_W-1:0]  pat;
  logic [LEFT_W-1:0] pat_len;
  logic              pat_st, pat_fd;

  assign stuff_due = (ones_q == STUFF_RUN);
  assign slot      = bit_tick && !stuff_due && (left_q == '0);
  assign in_ready  = slot && wants_byte;
  assign load      = in_ready && in_valid;

  hdlc_tx_plan u_plan (
    .phase_q     (phase_q),
    .last_flag_q (lf_q),
    .in_valid    (in_valid),
    .idle_ones   (idle_ones),
    .crc_at_end  (crc_at_end),
    .urun_mode   (urun_mode),
    .tag_eof     (tag_eof),
    .seg_sel     (seg_sel),
    .phase_nx    (phase_nx),
    .lf_nx       (lf_nx),
    .wants_byte  (wants_byte),
    .urun_hit    (urun_hit)
  );

  hdlc_tx_eof_tag #(
    .CNT_W        (CNT_W),
    .HAS_CHAR_CNT (HAS_CHAR_CNT)
  ) u_tag (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .in_eof     (in_eof),
    .set_eof    (set_eof),
    .cnt_load   (cnt_load),
    .cnt_preset (cnt_preset),
    .tag_eof    (tag_eof)
  );

  hdlc_tx_crc16 u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .init  (load && (phase_q == PH_IDLE)),
    .feed  (feed),
    .din   (out_bit),
    .crc_q (crc_q)
  );

  // segment pattern, length and handling for the chosen segment
  always_comb begin
    pat     = '1;
    pat_len = LEFT_W'(1);
    pat_st  = 1'b0;
    pat_fd  = 1'b0;
    unique case (seg_sel)
      SEG_FLAG: begin
        pat     = SEG_W'(FLAG_OCTET);
        pat_len = LEFT_W'(BYTE_W);
      end
      SEG_MARK:    pat_len = LEFT_W'(BYTE_W);
      SEG_DATA: begin
        pat     = SEG_W'(in_data);
        pat_len = LEFT_W'(BYTE_W);
        pat_st  = 1'b1;
        pat_fd  = 1'b1;
      end
      SEG_CRC: begin
        pat     = ~crc_q;
        pat_len = LEFT_W'(CRC_W);
        pat_st  = 1'b1;
      end
      SEG_ABORT7:  pat_len = LEFT_W'(ABORT_SHORT);
      SEG_ABORT15: pat_len = LEFT_W'(ABORT_LONG);
      default: ;
    endcase
  end

  // one line bit per tick: stuffed zero, current segment, or a new segment
  always_comb begin
    sh_d    = sh_q;
    left_d  = left_q;
    st_d    = st_q;
    fd_d    = fd_q;
    ones_d  = ones_q;
    phase_d = phase_q;
    lf_d    = lf_q;
    out_bit = bit_q;
    cur_st  = 1'b0;
    feed    = 1'b0;
    if (bit_tick) begin
      if (stuff_due) begin
        out_bit = 1'b0;
        ones_d  = '0;
      end else begin
        if (left_q != '0) begin
          out_bit = sh_q[0];
          sh_d    = {1'b1, sh_q[SEG_W-1:1]};
          left_d  = left_q - LEFT_W'(1);
          cur_st  = st_q;
          feed    = fd_q;
        end else begin
          out_bit = pat[0];
          sh_d    = {1'b1, pat[SEG_W-1:1]};
          left_d  = pat_len - LEFT_W'(1);
          st_d    = pat_st;
          fd_d    = pat_fd;
          cur_st  = pat_st;
          feed    = pat_fd;
          phase_d = phase_nx;
          lf_d    = lf_nx;
        end
        if (cur_st && out_bit) ones_d = ones_q + RUN_W'(1);
        else                   ones_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '1;
      left_q  <= '0;
      st_q    <= 1'b0;
      fd_q    <= 1'b0;
      ones_q  <= '0;
      phase_q <= PH_IDLE;
      lf_q    <= 1'b0;
      bit_q   <= 1'b1;
      en_q    <= 1'b0;
      ur_q    <= 1'b0;
      fe_q    <= 1'b0;
    end else begin
      sh_q    <= sh_d;
      left_q  <= left_d;
      st_q    <= st_d;
      fd_q    <= fd_d;
      ones_q  <= ones_d;
      phase_q <= phase_d;
      lf_q    <= lf_d;
      bit_q   <= out_bit;
      en_q    <= bit_tick;
      ur_q    <= slot && urun_hit;
      fe_q    <= load && tag_eof;
    end
  end

  assign tx_bit       = bit_q;
  assign tx_bit_en    = en_q;
  assign tx_underrun  = ur_q;
  assign tx_frame_end = fe_q;

  // R2
  en_follows_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> tx_bit_en);

  // R2
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_bit_en |-> $stable(tx_bit));

  // R3
  ready_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> bit_tick);

  // R5
  stuff_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && (ones_q == STUFF_RUN)) |=> !tx_bit);

  // R5
  run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q <= STUFF_RUN);

  // R11
  urun_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_underrun |-> !tx_frame_end);

  // R11
  urun_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_underrun |-> ($past(phase_q) == PH_BODY));
endmodule

// File: tb/hdlc_tx_framer_test.sv
module hdlc_tx_framer_test;
  localparam int CNT_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] in_data = 8'h00;
  logic in_eof = 1'b0;
  logic idle_ones = 1'b0;
  logic crc_at_end = 1'b1;
  logic [1:0] urun_mode = 2'd0;
  logic set_eof = 1'b0;
  logic cnt_load = 1'b0;
  logic [CNT_W-1:0] cnt_preset = '0;
  logic tx_bit, tx_bit_en, tx_underrun, tx_frame_end;

  hdlc_tx_framer #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_eof(in_eof),
    .idle_ones(idle_ones), .crc_at_end(crc_at_end), .urun_mode(urun_mode),
    .set_eof(set_eof), .cnt_load(cnt_load), .cnt_preset(cnt_preset),
    .tx_bit(tx_bit), .tx_bit_en(tx_bit_en),
    .tx_underrun(tx_underrun), .tx_frame_end(tx_frame_end)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // ---------------- reference model ----------------
  bit    mq_b[$];
  bit    mq_s[$];
  string mq_t[$];
  int    m_ones = 0;
  int    m_phase = 0;
  bit    m_lf = 0;
  bit    m_after_abort = 0;
  logic [15:0] m_crc = 16'hFFFF;
  int    m_cnt = 0;
  bit    m_pend = 0;
  bit    m_acc = 0;
  bit    exp_bit = 1, exp_en = 0, exp_ur = 0, exp_fe = 0;
  string exp_tag = "R1";

  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) begin
      bit f = r[0] ^ d[i];
      r = r >> 1;
      if (f) r = r ^ 16'h8408;
    end
    return r;
  endfunction

  function automatic bit m_ready_now();
    return bit_tick && (m_ones != 5) && (mq_b.size() == 0) &&
           ((m_phase == 1) || (m_phase == 0 && m_lf));
  endfunction

  task automatic m_push(input logic [15:0] v, input int n, input bit st, input string tg);
    for (int i = 0; i < n; i++) begin
      mq_b.push_back(v[i]);
      mq_s.push_back(st);
      mq_t.push_back(tg);
    end
  endtask

  task automatic m_flag(input string tg);
    m_push(16'h007E, 8, 0, m_after_abort ? "R12" : tg);
    m_after_abort = 0;
  endtask

  task automatic m_load(input string tg);
    bit eof;
    eof = in_eof || m_pend || set_eof || (m_cnt == 1);   // R7
    m_pend = 0;
    if (m_cnt != 0) m_cnt--;
    if (m_phase == 0) m_crc = 16'hFFFF;
    m_crc = crc_byte(m_crc, in_data);
    m_push({8'h00, in_data}, 8, 1, tg);
    exp_fe = eof;
    m_phase = eof ? (crc_at_end ? 2 : 3) : 1;
    m_acc = 1;
  endtask

  task automatic m_decide();
    case (m_phase)
      0: begin
        if (m_lf && in_valid) m_load("R9");
        else if (in_valid || !idle_ones) begin m_flag(in_valid ? "R4" : "R10"); m_lf = 1; end
        else begin m_push(16'h00FF, 8, 0, "R10"); m_lf = 0; end
      end
      1: begin
        if (in_valid) m_load("R4");
        else begin
          exp_ur = 1;  // R11
          case (urun_mode)
            2'd0: begin m_push(16'h7FFF, 7, 0, "R11"); m_phase = 0; m_lf = 0; m_after_abort = 1; end
            2'd1: begin m_push(16'h7FFF, 15, 0, "R11"); m_phase = 0; m_lf = 0; m_after_abort = 1; end
            2'd2: begin m_push(16'h007E, 8, 0, "R11"); m_phase = 0; m_lf = 1; end
            default: begin m_push(~m_crc, 16, 1, "R11"); m_phase = 3; end
          endcase
        end
      end
      2: begin m_push(~m_crc, 16, 1, "R6"); m_phase = 3; end
      default: begin m_flag("R8"); m_phase = 0; m_lf = 1; end
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mq_b.delete(); mq_s.delete(); mq_t.delete();
      m_ones = 0; m_phase = 0; m_lf = 0; m_after_abort = 0;
      m_crc = 16'hFFFF; m_cnt = 0; m_pend = 0; m_acc = 0;
      exp_bit = 1; exp_en = 0; exp_ur = 0; exp_fe = 0; exp_tag = "R1";
    end else begin
      bit b, s;
      exp_en = bit_tick; exp_ur = 0; exp_fe = 0; m_acc = 0;
      if (bit_tick) begin
        if (m_ones == 5) begin
          exp_bit = 0; m_ones = 0; exp_tag = "R5";
        end else begin
          if (mq_b.size() == 0) m_decide();
          b = mq_b.pop_front(); s = mq_s.pop_front(); exp_tag = mq_t.pop_front();
          exp_bit = b;
          m_ones = (s && b) ? m_ones + 1 : 0;
        end
      end
      if (set_eof && !m_acc) m_pend = 1;
      if (cnt_load) m_cnt = int'(cnt_preset);
    end
  end

  // ---------------- source and tick drive ----------------
  logic [7:0] src_d[$];
  bit         src_e[$];
  int         src_g[$];
  bit         tick_every = 1;
  logic [6:0] lfsr = 7'h5A;
  int         n_ur = 0, n_fe = 0;

  task automatic push_byte(input logic [7:0] d, input bit e, input int gap);
    src_d.push_back(d); src_e.push_back(e); src_g.push_back(gap);
  endtask

  always @(negedge clk) begin
    cyc++;
    // compare registered outputs with the model
    check(tx_bit_en == exp_en, rst_n ? "R2" : "R1", "tx_bit_en", tx_bit_en, exp_en);
    check(tx_bit == exp_bit, rst_n ? exp_tag : "R1", "tx_bit", tx_bit, exp_bit);
    check(tx_underrun == exp_ur, rst_n ? "R11" : "R1", "tx_underrun", tx_underrun, exp_ur);
    check(tx_frame_end == exp_fe, rst_n ? "R7" : "R1", "tx_frame_end", tx_frame_end, exp_fe);
    if (tx_underrun) n_ur++;
    if (tx_frame_end) n_fe++;
    // drive next inputs
    if (m_acc) begin
      void'(src_d.pop_front()); void'(src_e.pop_front()); void'(src_g.pop_front());
      m_acc = 0;
    end
    lfsr = {lfsr[5:0], lfsr[6] ^ lfsr[5]};
    bit_tick = rst_n && (tick_every || lfsr[0] || lfsr[2]);
    if (src_d.size() != 0 && src_g[0] > 0) begin
      src_g[0] = src_g[0] - 1;
      in_valid = 0;
    end else if (src_d.size() != 0) begin
      in_valid = 1; in_data = src_d[0]; in_eof = src_e[0];
    end else begin
      in_valid = 0; in_eof = 0;
    end
    #1;
    check(in_ready == m_ready_now(), rst_n ? "R3" : "R1", "in_ready", in_ready, m_ready_now());
  end

  always @(posedge clk) if (cyc > 150000) begin
    check(0, "WD", "watchdog", cyc, 150000);
    finish_run();
  end

  task automatic drain();
    while (src_d.size() != 0) @(negedge clk);
    repeat (300) @(negedge clk);
  endtask

  task automatic expect_counts(input int ur, input int fe, input string tag);
    check(n_ur == ur, "R11", {tag, " underrun count"}, n_ur, ur);
    check(n_fe == fe, "R7", {tag, " frame_end count"}, n_fe, fe);
    n_ur = 0; n_fe = 0;
  endtask

  task automatic strobe_set_eof();
    @(negedge clk); set_eof = 1; @(negedge clk); set_eof = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (60) @(negedge clk);      // R10 idle flags
    n_ur = 0; n_fe = 0;

    // R5 R6 R8 R9: all-ones data, back-to-back frames sharing a flag
    push_byte(8'hFF, 0, 0); push_byte(8'hFF, 0, 0); push_byte(8'h3E, 1, 0);
    push_byte(8'hA5, 0, 0); push_byte(8'hFF, 1, 0);
    drain();
    expect_counts(0, 2, "shared-flag");

    // R11 each underrun mode, irregular ticks
    tick_every = 0;
    for (int m = 0; m < 4; m++) begin
      urun_mode = 2'(m);
      crc_at_end = (m != 2);
      push_byte(8'hF8, 0, 0); push_byte(8'h1F, 0, 0); push_byte(8'h55, 1, 90);
      drain();
      expect_counts(1, 1, "underrun");
    end

    // R10 R12 idle ones, set_eof command tags the next byte (R7)
    idle_ones = 1; urun_mode = 2'd1; crc_at_end = 1;
    repeat (40) @(negedge clk);
    strobe_set_eof();
    push_byte(8'h7E, 0, 0); push_byte(8'hFF, 0, 0); push_byte(8'h0F, 1, 0);
    drain();
    expect_counts(0, 2, "set_eof");

    // R7 character counter, preset 3; load collides with bytes in flight
    idle_ones = 0; tick_every = 1;
    @(negedge clk); cnt_preset = 12'd3; cnt_load = 1; @(negedge clk); cnt_load = 0;
    push_byte(8'h01, 0, 0); push_byte(8'h80, 0, 0); push_byte(8'hFE, 0, 0);
    push_byte(8'h7F, 0, 0); push_byte(8'hC3, 1, 0);
    drain();
    expect_counts(0, 2, "counter");

    // R12 abort then restart, plus set_eof in a load-heavy stream
    urun_mode = 2'd0; tick_every = 0;
    push_byte(8'hFF, 0, 0); push_byte(8'hFF, 0, 40); push_byte(8'h11, 1, 0);
    fork strobe_set_eof(); join_none
    drain();
    finish_run();
  end
endmodule